// File: doc/BRIEF.md
# Write-Only Push-Pull Serial Bus Master

This block drives a two-wire serial bus of the unidirectional, push-pull kind. The master owns both the clock line and the data line outright. Data only ever travels from master to target, so the block never reads the bus back. It has no acknowledge sampling, no arbitration, no clock synchronization and no wait for a target to release the clock. A host hands over one command per transfer through a valid/ready handshake. The command carries a target address, a byte count and option flags. The host then streams the data bytes through a second valid/ready handshake.

For each command the block emits the following on the wires: START, the address byte or bytes with the direction bit fixed at write, the payload bytes MSB first, and STOP. It then gives a one-cycle completion pulse. Each byte is followed by a ninth clock with the data line high, so the bit framing matches ordinary targets. Three options are chosen per command:
- two-byte (10-bit) target addressing;
- the broadcast address 0x00, optionally followed by the reset code 0x06;
- a leading 0x01 prefix byte, closed by a repeated START.

The bus rate comes from a runtime divider of the system clock.

Top module: `ufm_master`

## Requirements
- R1: After reset, and whenever no transfer is in progress, `scl` and `sda` are both 1, `cmd_ready` is 1 and `dat_ready` is 0.
- R2: A plain transfer is START, then the byte {cmd_addr[6:0], 0}, then `cmd_len` host bytes in the order they are accepted, then STOP. Every byte is sent MSB first, one bit per `scl` high phase, and is followed by a ninth `scl` pulse with `sda` = 1.
- R3: `sda` changes only while `scl` is low, except for START (`sda` falls with `scl` high) and STOP (`sda` rises with `scl` high). `scl` and `sda` never change on the same system clock.
- R4: While data is available, every low phase of `scl` lasts exactly `div` system clocks (`div` ≥ 2). Each high phase of a bit also lasts `div` clocks.
- R5: With `cmd_ten` = 1, the address is two bytes: {11110, cmd_addr[9:8], 0} and then cmd_addr[7:0].
- R6: With `cmd_gcall` = 1 and `cmd_swrst` = 0, the address byte is 0x00, followed by the `cmd_len` host bytes.
- R7: With `cmd_gcall` = 1 and `cmd_swrst` = 1, the address byte 0x00 is followed by exactly one byte 0x06. `cmd_len` is ignored and `dat_ready` stays 0 for the whole transfer.
- R8: With `cmd_sbyte` = 1, the byte 0x01 follows the first START. Then a repeated START comes (`sda` high, `scl` high, `sda` falls), and after it the normal address and payload.
- R9: `done` is a single-cycle pulse given with `scl` high and `sda` low, one clock before the STOP edge. `cmd_ready` returns once both lines are high again.
- R10: With `cmd_len` = 0 and no reset code, the transfer is START, the address byte or bytes, and STOP, with no host bytes requested.

Assumption on ports: `dat_ready` and `done` are outputs, and `cmd_ready` is an output. The table below lists every port of `ufm_master` in port-list order, assuming that `dat_ready` follows `dat_valid` in the list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div | input | DIVW | System clocks per bus half-period (≥ 2) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block is idle and accepts a command |
| cmd_addr | input | 10 | Target address (bits 6:0 used in 7-bit mode) |
| cmd_ten | input | 1 | Use two-byte addressing |
| cmd_gcall | input | 1 | Send the broadcast address 0x00 |
| cmd_swrst | input | 1 | After the broadcast address, send the reset code 0x06 |
| cmd_sbyte | input | 1 | Prefix the transfer with 0x01 and a repeated START |
| cmd_len | input | CNTW | Number of host payload bytes |
| dat_valid | input | 1 | Payload byte offered |
| dat_ready | output | 1 | Block accepts a payload byte |
| dat_byte | input | 8 | Payload byte |
| done | output | 1 | One-cycle end-of-transfer pulse |
| scl | output | 1 | Bus clock line, push-pull |
| sda | output | 1 | Bus data line, push-pull |

## Verification
The timing is as follows:
- Once a command is accepted, the first bus event, the falling `sda` of START, appears `div` + 1 clocks later.
- After that, every `scl` edge follows the previous one after exactly `div` clocks.
- Each `sda` change lags the `scl` fall that allows it by one clock.
- `done` comes one clock before the STOP rise.

The bench therefore never predicts absolute cycles for bus events. A monitor samples both lines on the falling system clock and decodes START, STOP, bits and ninth bits from edge pairs. It measures each `scl` low phase in clocks against `div`. After seeing `done`, it waits two clocks before checking that the expected-event queue is empty and that the lines are idle.

// File: rtl/ufm_pkg.sv
package ufm_pkg;

    typedef enum logic [2:0] {
        SEG_IDLE, SEG_START, SEG_BITS, SEG_RSTART, SEG_STOP
    } seg_e;

    typedef enum logic [2:0] {
        STG_SBYTE, STG_A7, STG_AHI, STG_ALO, STG_GC, STG_SWR, STG_DATA, STG_END
    } stg_e;

    typedef struct packed {
        logic [9:0] addr;
        logic       ten;
        logic       gcall;
        logic       swrst;
        logic       sbyte;
    } req_t;

    localparam logic [7:0] PREFIX_BYTE = 8'h01;
    localparam logic [7:0] BCAST_BYTE  = 8'h00;
    localparam logic [7:0] RESET_CODE  = 8'h06;
    localparam logic [4:0] TEN_MARK    = 5'b11110;

    function automatic stg_e first_addr(req_t r);
        if (r.gcall)    return STG_GC;
        else if (r.ten) return STG_AHI;
        else            return STG_A7;
    endfunction

    function automatic stg_e stage_after(stg_e s, req_t r, logic more);
        case (s)
            STG_SBYTE:        return first_addr(r);
            STG_AHI:          return STG_ALO;
            STG_GC:           return r.swrst ? STG_SWR : (more ? STG_DATA : STG_END);
            STG_SWR, STG_END: return STG_END;
            default:          return more ? STG_DATA : STG_END;
        endcase
    endfunction

    function automatic logic [7:0] stage_byte(stg_e s, req_t r, logic [7:0] d);
        case (s)
            STG_SBYTE: return PREFIX_BYTE;
            STG_A7:    return {r.addr[6:0], 1'b0};
            STG_AHI:   return {TEN_MARK, r.addr[9:8], 1'b0};
            STG_ALO:   return r.addr[7:0];
            STG_GC:    return BCAST_BYTE;
            STG_SWR:   return RESET_CODE;
            default:   return d;
        endcase
    endfunction

endpackage

// File: rtl/ufm_tick.sv
module ufm_tick #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt;

    assign tick = run && (cnt == div - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ufm_hold.sv
module ufm_hold #(
    parameter int CNTW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [CNTW-1:0] n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [7:0]      in_data,
    input  logic            take,
    output logic            full,
    output logic [7:0]      data
);
    logic [CNTW-1:0] fet;

    assign in_ready = !full && (fet != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            fet  <= '0;
            full <= 1'b0;
            data <= '0;
        end else if (start) begin
            fet  <= n;
            full <= 1'b0;
        end else if (in_valid && in_ready) begin
            data <= in_data;
            full <= 1'b1;
            fet  <= fet - 1'b1;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/ufm_master.sv
module ufm_master
    import ufm_pkg::*;
#(
    parameter int DIVW = 8,
    parameter int CNTW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DIVW-1:0] div,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [9:0]      cmd_addr,
    input  logic            cmd_ten,
    input  logic            cmd_gcall,
    input  logic            cmd_swrst,
    input  logic            cmd_sbyte,
    input  logic [CNTW-1:0] cmd_len,
    input  logic            dat_valid,
    output logic            dat_ready,
    input  logic [7:0]      dat_byte,
    output logic            done,
    output logic            scl,
    output logic            sda
);
    localparam int BITW = 4;
    localparam logic [BITW-1:0] LAST_BIT = BITW'(8);

    seg_e            seg;
    stg_e            stg;
    req_t            req;
    logic [1:0]      ph;
    logic [BITW-1:0] bitn;
    logic [7:0]      sh;
    logic [CNTW-1:0] rem;
    logic            need_rs, scl_q, sda_nx, sda_q, done_q;
    logic            tick, fire, full, take, go_load, can_load, more_after;
    logic [7:0]      hold_data, ld_byte;
    logic [CNTW-1:0] eff_len;

    assign cmd_ready = (seg == SEG_IDLE) && scl_q && sda_q;
    assign fire      = cmd_valid && cmd_ready;
    assign eff_len   = (cmd_gcall && cmd_swrst) ? '0 : cmd_len;
    assign scl       = scl_q;
    assign sda       = sda_q;
    assign done      = done_q;

    ufm_tick #(.DIVW(DIVW)) u_tick (
        .clk(clk), .rst(rst), .run(seg != SEG_IDLE), .div(div), .tick(tick)
    );

    ufm_hold #(.CNTW(CNTW)) u_hold (
        .clk(clk), .rst(rst), .start(fire), .n(eff_len),
        .in_valid(dat_valid), .in_ready(dat_ready), .in_data(dat_byte),
        .take(take), .full(full), .data(hold_data)
    );

    always_comb begin
        can_load   = (stg != STG_DATA) || full;
        more_after = (stg == STG_DATA) ? (rem != CNTW'(1)) : (rem != '0);
        ld_byte    = stage_byte(stg, req, hold_data);
        go_load    = tick && can_load &&
                     ((seg == SEG_START  && ph == 2'd1) ||
                      (seg == SEG_RSTART && ph == 2'd2) ||
                      (seg == SEG_BITS && scl_q && bitn == LAST_BIT &&
                       !need_rs && stg != STG_END));
        take       = go_load && (stg == STG_DATA);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg     <= SEG_IDLE;
            stg     <= STG_END;
            req     <= '0;
            ph      <= '0;
            bitn    <= '0;
            sh      <= '0;
            rem     <= '0;
            need_rs <= 1'b0;
            scl_q   <= 1'b1;
            sda_nx  <= 1'b1;
            sda_q   <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            sda_q  <= sda_nx;
            done_q <= 1'b0;
            case (seg)
                SEG_IDLE: if (fire) begin
                    req <= '{addr: cmd_addr, ten: cmd_ten, gcall: cmd_gcall,
                             swrst: cmd_swrst, sbyte: cmd_sbyte};
                    rem <= eff_len;
                    stg <= cmd_sbyte ? STG_SBYTE
                         : first_addr('{addr: cmd_addr, ten: cmd_ten, gcall: cmd_gcall,
                                        swrst: cmd_swrst, sbyte: cmd_sbyte});
                    seg <= SEG_START;
                    ph  <= '0;
                end
                SEG_START: if (tick && ph == 2'd0) begin
                    sda_nx <= 1'b0;
                    ph     <= 2'd1;
                end
                SEG_BITS: if (tick) begin
                    if (!scl_q) begin
                        scl_q <= 1'b1;
                    end else if (bitn != LAST_BIT) begin
                        scl_q  <= 1'b0;
                        sda_nx <= (bitn == LAST_BIT - 1'b1) ? 1'b1 : sh[6];
                        sh     <= {sh[6:0], 1'b0};
                        bitn   <= bitn + 1'b1;
                    end else if (need_rs) begin
                        scl_q   <= 1'b0;
                        sda_nx  <= 1'b1;
                        need_rs <= 1'b0;
                        seg     <= SEG_RSTART;
                        ph      <= '0;
                    end else if (stg == STG_END) begin
                        scl_q  <= 1'b0;
                        sda_nx <= 1'b0;
                        seg    <= SEG_STOP;
                        ph     <= '0;
                    end
                end
                SEG_RSTART: if (tick) begin
                    if (ph == 2'd0) begin
                        scl_q <= 1'b1;
                        ph    <= 2'd1;
                    end else if (ph == 2'd1) begin
                        sda_nx <= 1'b0;
                        ph     <= 2'd2;
                    end
                end
                SEG_STOP: if (tick) begin
                    if (ph == 2'd0) begin
                        scl_q <= 1'b1;
                        ph    <= 2'd1;
                    end else begin
                        sda_nx <= 1'b1;
                        done_q <= 1'b1;
                        seg    <= SEG_IDLE;
                    end
                end
                default: seg <= SEG_IDLE;
            endcase
            if (go_load) begin
                scl_q   <= 1'b0;
                sh      <= ld_byte;
                sda_nx  <= ld_byte[7];
                bitn    <= '0;
                seg     <= SEG_BITS;
                stg     <= stage_after(stg, req, more_after);
                need_rs <= (stg == STG_SBYTE);
                if (stg == STG_DATA) rem <= rem - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ufm_master_chk.sv
module ufm_master_chk (
    input logic clk,
    input logic rst,
    input logic cmd_ready,
    input logic dat_ready,
    input logic done,
    input logic scl,
    input logic sda
);
    // R1
    a_r1_idle_clock_high: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (scl && sda && !dat_ready));

    // R3
    a_r3_no_joint_edge: assert property (@(posedge clk) disable iff (rst)
        !$stable(scl) |-> $stable(sda));

    // R3
    a_r3_high_edge_only_at_frame: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda) && scl) |-> $past(done));

    // R9
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    a_r9_done_before_stop: assert property (@(posedge clk) disable iff (rst)
        done |-> (scl && !sda));

    // R9
    a_r9_stop_follows_done: assert property (@(posedge clk) disable iff (rst)
        done |=> (scl && sda && cmd_ready));
endmodule

bind ufm_master ufm_master_chk u_chk (
    .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .dat_ready(dat_ready),
    .done(done), .scl(scl), .sda(sda)
);

// File: tb/ufm_master_test.sv
module ufm_master_test;
    localparam int DIVW = 8;
    localparam int CNTW = 8;
    localparam int EV_START = 256;
    localparam int EV_STOP  = 512;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [DIVW-1:0] div = DIVW'(4);
    logic            cmd_valid = 1'b0, cmd_ready;
    logic [9:0]      cmd_addr = '0;
    logic            cmd_ten = 1'b0, cmd_gcall = 1'b0, cmd_swrst = 1'b0, cmd_sbyte = 1'b0;
    logic [CNTW-1:0] cmd_len = '0;
    logic            dat_valid = 1'b0, dat_ready;
    logic [7:0]      dat_byte = '0;
    logic            done, scl, sda;

    int    errors = 0, checks = 0;
    int    exp_q[$];
    string tag_q[$];
    int    joint_edges = 0, rdy_seen = 0;

    always #10 clk = ~clk;

    ufm_master #(.DIVW(DIVW), .CNTW(CNTW)) uut (
        .clk(clk), .rst(rst), .div(div),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_ten(cmd_ten), .cmd_gcall(cmd_gcall), .cmd_swrst(cmd_swrst),
        .cmd_sbyte(cmd_sbyte), .cmd_len(cmd_len),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
        .done(done), .scl(scl), .sda(sda)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic push(input int v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // Monitor: decodes bus events and checks them against the scoreboard
    logic p_scl = 1'b1, p_sda = 1'b1;
    int   bitc = 0, lowc = 0;
    logic [7:0] shreg = '0;

    task automatic got(input int v);
        if (exp_q.size() == 0) begin
            check(0, "R2 unexpected bus event", v, -1);
        end else begin
            int e = exp_q.pop_front();
            string t = tag_q.pop_front();
            check(v == e, t, v, e);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (scl != p_scl && sda != p_sda) joint_edges++;
            if (dat_ready) rdy_seen++;
            if (!scl) lowc++;
            if (p_scl && scl && p_sda && !sda) begin
                got(EV_START);
                bitc = 0;
            end else if (p_scl && scl && !p_sda && sda) begin
                got(EV_STOP);
            end else if (!p_scl && scl) begin
                check(lowc == int'(div), "R4 scl low width", lowc, int'(div));
                if (bitc < 8) begin
                    shreg = {shreg[6:0], sda};
                    bitc++;
                end else begin
                    check(sda == 1'b1, "R2 ninth bit high", sda, 1);
                    got(int'(shreg));
                    bitc = 0;
                end
            end
            if (scl) lowc = 0;
            p_scl = scl;
            p_sda = sda;
        end
    end

    function automatic logic [7:0] pay(input int i, input int seed);
        return 8'((i * 37 + seed * 11) & 255);
    endfunction

    task automatic xfer(input logic [9:0] a, input bit ten, input bit gc, input bit sw,
                        input bit sb, input int n, input int seed, input string tag);
        bool_t_dummy: begin end
        push(EV_START, {tag, " START"});
        if (sb) begin
            push(8'h01, {tag, " R8 prefix byte"});
            push(EV_START, {tag, " R8 repeated START"});
        end
        if (gc)       push(8'h00, {tag, " R6 broadcast address"});
        else if (ten) begin
            push({5'b11110, a[9:8], 1'b0}, {tag, " R5 high address byte"});
            push(a[7:0], {tag, " R5 low address byte"});
        end else      push({a[6:0], 1'b0}, {tag, " R2 address byte"});
        if (gc && sw) push(8'h06, {tag, " R7 reset code"});
        else for (int i = 0; i < n; i++) push(pay(i, seed), {tag, " R2 payload"});
        push(EV_STOP, {tag, " STOP"});

        rdy_seen = 0;
        @(negedge clk);
        cmd_addr = a; cmd_ten = ten; cmd_gcall = gc; cmd_swrst = sw;
        cmd_sbyte = sb; cmd_len = CNTW'(n); cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (!(gc && sw)) begin
            for (int i = 0; i < n; i++) begin
                dat_byte = pay(i, seed);
                dat_valid = 1'b1;
                while (!dat_ready) @(negedge clk);
                @(negedge clk);
                dat_valid = 1'b0;
            end
        end
        while (!done) @(negedge clk);
        check(scl && !sda, {tag, " R9 done with scl high sda low"}, {scl, sda}, 2);
        @(negedge clk);
        check(!done, {tag, " R9 done single cycle"}, done, 0);
        @(negedge clk);
        check(exp_q.size() == 0, {tag, " R9 all events before idle"}, exp_q.size(), 0);
        check(cmd_ready && scl && sda, {tag, " R1 idle after transfer"},
              {cmd_ready, scl, sda}, 7);
        if (gc && sw) check(rdy_seen == 0, {tag, " R7 no payload requested"}, rdy_seen, 0);
        if (n == 0 && !(gc && sw))
            check(rdy_seen == 0, {tag, " R10 no payload requested"}, rdy_seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(scl && sda && cmd_ready && !dat_ready && !done, "R1 reset state",
              {scl, sda, cmd_ready, dat_ready, done}, 5'b11100);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(scl && sda && cmd_ready, "R1 idle after reset", {scl, sda, cmd_ready}, 7);

        xfer(10'h05A, 0, 0, 0, 0, 3, 1, "T1 R2 plain");
        xfer(10'h013, 0, 0, 0, 0, 0, 2, "T2 R10 empty");
        xfer(10'h2C5, 1, 0, 0, 0, 2, 3, "T3 R5 ten-bit");
        xfer(10'h000, 0, 1, 0, 0, 2, 4, "T4 R6 broadcast");
        xfer(10'h000, 0, 1, 1, 0, 5, 5, "T5 R7 reset code");
        xfer(10'h07F, 0, 0, 0, 1, 1, 6, "T6 R8 prefix");
        div = DIVW'(2);
        xfer(10'h3A1, 1, 0, 0, 1, 2, 7, "T7 R4 R8 fast ten-bit");
        div = DIVW'(7);
        xfer(10'h001, 0, 0, 0, 0, 4, 8, "T8 R4 slow");
        check(joint_edges == 0, "R3 no joint scl/sda edge", joint_edges, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule